// File: doc/BRIEF.md
# Indirect Read Buffer Engine

This block moves a block of data from flash memory to a host through an on-chip word buffer. Software first programs the flash source address, the transfer length in bytes, a trigger address, a fill watermark and the DMA request sizes. It then sets the start bit. Until then nothing is fetched.

Once running, the engine presents word fetch requests on a simplified flash-side port and stores each returned word in the buffer. The host drains the buffer by reading the trigger address over and over. Each such read returns the next buffered word in fetch order. The host can read the buffer fill level at any time. There are two ways to pace the host. Without DMA, a level-sensitive watermark interrupt is raised while the buffer holds at least the watermark amount. With DMA enabled, the engine raises burst or single DMA requests sized by the programmed byte counts and gated by the watermark. When every requested byte has been read out, a done status bit and a completion interrupt are set.

Host register map (word offsets on `host_addr`):
- 0: control/status.
- 1: flash source address.
- 2: length in bytes.
- 3: trigger address.
- 4: watermark in bytes.
- 5: DMA sizes, with single bytes in [15:0] and burst bytes in [31:16].
- 6: fill level in bytes, read-only.

Control bits:
- Bit 0: start on write, busy on read.
- Bit 1: done. Writing 1 clears it.
- Bit 2: underflow. Writing 1 clears it.
- Bit 3: DMA enable. It is latched at start.

A read whose address equals the trigger register is served from the buffer and takes priority over the register decode. Read data is returned with `host_rvalid` in the cycle after `host_rd`.

Top module: `irb_engine`

## Requirements
- R1: After reset, control reads 0, the fill register reads 0, and `fl_req`, `irq_wm`, `irq_done`, `dma_single_req` and `dma_burst_req` are all low.
- R2: `fl_req` stays low until a start is written. After start, the address of fetch k is the source address plus 4·k.
- R3: A host read returns its data with `host_rvalid` one cycle later. Trigger reads return the fetched words in fetch order.
- R4: The fill register (offset 6) reads 4 times the number of words currently buffered.
- R5: `irq_wm` is high while a transfer is busy, the watermark is non-zero, and the fill in bytes is at least the watermark.
- R6: Fetching stalls (`fl_req` low) while the buffer holds DEPTH words, so no fetched word is lost.
- R7: With DMA enabled, `dma_burst_req` rises when no request is outstanding and the fill is at least the burst size and at least the watermark. This needs at least a burst still left to read. The request drops in the cycle after `dma_ack`, and no new request appears until that many trigger reads are done.
- R8: With DMA enabled and fewer than a burst's bytes remaining, `dma_single_req` rises instead, once the fill covers the smaller of the single size and the remaining bytes.
- R9: When the last word is read out, busy clears and the done bit (control bit 1) and `irq_done` are set. Writing 1 to bit 1 clears them.
- R10: A start written while a transfer is busy is ignored. Busy stays set and the running transfer's addresses and data are unchanged.
- R11: A trigger read from an empty buffer returns 0 and sets the sticky underflow bit (control bit 2). Writing 1 to bit 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| fl_req | output | 1 | Engine wants the next flash word |
| fl_addr | output | FADDR_W | Byte address of the requested flash word |
| fl_valid | input | 1 | Flash word present; accepted when fl_req is high |
| fl_data | input | DATA_W | Flash word |
| dma_single_req | output | 1 | Single-size DMA request |
| dma_burst_req | output | 1 | Burst-size DMA request |
| dma_ack | input | 1 | DMA controller accepted the pending request |
| irq_wm | output | 1 | Watermark interrupt, level |
| irq_done | output | 1 | Transfer complete interrupt, level |

## Verification
Some properties are checked on every cycle:
- the buffer never exceeds its depth, and fetching is withheld while it is full;
- the two DMA requests are never high together, and both fall right after an acknowledge;
- done stays set until it is cleared or restarted, and never coexists with busy;
- each read strobe returns data one cycle later.

Other behaviours need the bench scenarios to show them: word ordering across a full-buffer stall, fetch addresses, fill readback, and watermark interrupt thresholds. The same holds for a rejected restart mid-transfer, the burst-to-single handover at the tail of a DMA transfer, underflow reads, and write-one-to-clear of the status bits.

// File: rtl/irb_pkg.sv
package irb_pkg;
  // Host register offsets (word addresses)
  localparam int OFS_CTRL  = 0;
  localparam int OFS_SRC   = 1;
  localparam int OFS_LEN   = 2;
  localparam int OFS_TRIG  = 3;
  localparam int OFS_WMARK = 4;
  localparam int OFS_DMASZ = 5;
  localparam int OFS_FILL  = 6;

  // Control/status bit positions
  localparam int CB_START = 0;  // write: start, read: busy
  localparam int CB_DONE  = 1;  // W1C
  localparam int CB_UFLOW = 2;  // W1C
  localparam int CB_DMA   = 3;  // latched at start
endpackage

// File: rtl/irb_fifo.sv
module irb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // Storage and registered read port, no reset: maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    if (do_pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/irb_dma_pacer.sv
module irb_dma_pacer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] left,
  input  logic [CNT_W-1:0] wm_words,
  input  logic [CNT_W-1:0] single_words,
  input  logic [CNT_W-1:0] burst_words,
  input  logic             pop,
  input  logic             ack,
  output logic             req_single,
  output logic             req_burst
);
  logic [CNT_W-1:0] pend;
  logic [CNT_W-1:0] single_need;
  logic             burst_ok, single_ok, tail;

  assign single_need = (left < single_words) ? left : single_words;
  assign tail        = (burst_words == '0) || (left < burst_words);

  assign burst_ok  = en && (pend == '0) && (burst_words != '0) &&
                     (left >= burst_words) && (fill >= burst_words) &&
                     (fill >= wm_words);
  assign single_ok = en && (pend == '0) && (single_words != '0) &&
                     (left != '0) && tail && (fill >= single_need);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend       <= '0;
      req_single <= 1'b0;
      req_burst  <= 1'b0;
    end else begin
      if (ack && req_burst)             pend <= burst_words;
      else if (ack && req_single)       pend <= single_need;
      else if (pop && (pend != '0))     pend <= pend - 1'b1;
      req_burst  <= burst_ok && !ack;
      req_single <= single_ok && !ack;
    end
  end
endmodule

// File: rtl/irb_engine.sv
module irb_engine
  import irb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int FADDR_W = 32,
  parameter int CNT_W   = 16,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               fl_req,
  output logic [FADDR_W-1:0] fl_addr,
  input  logic               fl_valid,
  input  logic [DATA_W-1:0]  fl_data,
  output logic               dma_single_req,
  output logic               dma_burst_req,
  input  logic               dma_ack,
  output logic               irq_wm,
  output logic               irq_done
);
  localparam int BPW   = DATA_W / 8;
  localparam int BSH   = $clog2(BPW);
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam int HALF  = DATA_W / 2;

  // Configuration
  logic [FADDR_W-1:0] src_q;
  logic [CNT_W-1:0]   len_q, wm_q, single_q, burst_q;
  logic [ADDR_W-1:0]  trig_q;
  // Transfer state
  logic               busy_q, done_q, uflow_q, dma_en_q;
  logic [CNT_W-1:0]   fetch_left, drain_left;
  logic [FADDR_W-1:0] fetch_addr;
  // Read path
  logic               rd_trig_q, rd_empty_q;
  logic [DATA_W-1:0]  reg_rdata_q;
  // Buffer
  logic [DATA_W-1:0]  fifo_rdata;
  logic [LVL_W-1:0]   fill;
  logic               full, empty;

  logic               ctrl_wr, launch, done_clr, uflow_clr;
  logic               trig_rd, push, pop_ok;
  logic [CNT_W-1:0]   len_words, fill_words, fill_bytes;

  assign ctrl_wr    = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
  assign launch     = ctrl_wr && host_wdata[CB_START] && !busy_q;
  assign done_clr   = ctrl_wr && host_wdata[CB_DONE];
  assign uflow_clr  = ctrl_wr && host_wdata[CB_UFLOW];
  assign trig_rd    = host_rd && (host_addr == trig_q);
  assign pop_ok     = trig_rd && !empty;
  assign len_words  = len_q >> BSH;
  assign fill_words = CNT_W'(fill);
  assign fill_bytes = fill_words << BSH;

  assign fl_req  = busy_q && (fetch_left != '0) && !full;
  assign fl_addr = fetch_addr;
  assign push    = fl_req && fl_valid;

  irb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (launch),
    .push  (push),
    .wdata (fl_data),
    .pop   (trig_rd),
    .rdata (fifo_rdata),
    .level (fill),
    .full  (full),
    .empty (empty)
  );

  irb_dma_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk          (clk),
    .rst          (rst),
    .en           (busy_q && dma_en_q),
    .fill         (fill_words),
    .left         (drain_left),
    .wm_words     (wm_q >> BSH),
    .single_words (single_q >> BSH),
    .burst_words  (burst_q >> BSH),
    .pop          (pop_ok),
    .ack          (dma_ack),
    .req_single   (dma_single_req),
    .req_burst    (dma_burst_req)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      len_q    <= '0;
      trig_q   <= '1;
      wm_q     <= '0;
      single_q <= '0;
      burst_q  <= '0;
    end else if (host_wr) begin
      case (host_addr)
        ADDR_W'(OFS_SRC):   src_q  <= FADDR_W'(host_wdata);
        ADDR_W'(OFS_LEN):   len_q  <= CNT_W'(host_wdata);
        ADDR_W'(OFS_TRIG):  trig_q <= ADDR_W'(host_wdata);
        ADDR_W'(OFS_WMARK): wm_q   <= CNT_W'(host_wdata);
        ADDR_W'(OFS_DMASZ): begin
          single_q <= CNT_W'(host_wdata[HALF-1:0]);
          burst_q  <= CNT_W'(host_wdata[DATA_W-1:HALF]);
        end
        default: ;
      endcase
    end
  end

  // Transfer sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      uflow_q    <= 1'b0;
      dma_en_q   <= 1'b0;
      fetch_left <= '0;
      drain_left <= '0;
      fetch_addr <= '0;
    end else begin
      if (launch) begin
        busy_q     <= (len_words != '0);
        done_q     <= (len_words == '0);
        dma_en_q   <= host_wdata[CB_DMA];
        fetch_left <= len_words;
        drain_left <= len_words;
        fetch_addr <= src_q;
      end else begin
        if (push) begin
          fetch_left <= fetch_left - 1'b1;
          fetch_addr <= fetch_addr + FADDR_W'(BPW);
        end
        if (pop_ok && busy_q) begin
          drain_left <= drain_left - 1'b1;
          if (drain_left == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else if (done_clr) begin
          done_q <= 1'b0;
        end
      end
      if (trig_rd && empty)  uflow_q <= 1'b1;
      else if (uflow_clr)    uflow_q <= 1'b0;
    end
  end

  // Interrupts
  always_ff @(posedge clk) begin
    if (rst) irq_wm <= 1'b0;
    else     irq_wm <= busy_q && (wm_q != '0) && (fill_bytes >= wm_q);
  end
  assign irq_done = done_q;

  // Host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      rd_trig_q   <= 1'b0;
      rd_empty_q  <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      host_rvalid <= host_rd;
      rd_trig_q   <= trig_rd;
      rd_empty_q  <= empty;
      reg_rdata_q <= '0;
      if (host_rd) begin
        case (host_addr)
          ADDR_W'(OFS_CTRL):  reg_rdata_q <= DATA_W'({dma_en_q, uflow_q, done_q, busy_q});
          ADDR_W'(OFS_SRC):   reg_rdata_q <= DATA_W'(src_q);
          ADDR_W'(OFS_LEN):   reg_rdata_q <= DATA_W'(len_q);
          ADDR_W'(OFS_TRIG):  reg_rdata_q <= DATA_W'(trig_q);
          ADDR_W'(OFS_WMARK): reg_rdata_q <= DATA_W'(wm_q);
          ADDR_W'(OFS_DMASZ): reg_rdata_q <= {HALF'(burst_q), HALF'(single_q)};
          ADDR_W'(OFS_FILL):  reg_rdata_q <= DATA_W'(fill_bytes);
          default:            reg_rdata_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = rd_trig_q ? (rd_empty_q ? '0 : fifo_rdata) : reg_rdata_q;
endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             launch,
  input logic             done_clr,
  input logic [LVL_W-1:0] fill,
  input logic             fl_req,
  input logic             host_rd,
  input logic             host_rvalid,
  input logic             dma_single_req,
  input logic             dma_burst_req,
  input logic             dma_ack
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= LVL_W'(DEPTH)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (fill == LVL_W'(DEPTH)) |-> !fl_req); // R6
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fl_req); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid); // R3
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(dma_single_req && dma_burst_req)); // R7
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && (dma_single_req || dma_burst_req)) |=> !(dma_single_req || dma_burst_req)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !done_clr && !launch) |=> done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
endmodule

bind irb_engine irb_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .busy           (busy_q),
  .done           (done_q),
  .launch         (launch),
  .done_clr       (done_clr),
  .fill           (fill),
  .fl_req         (fl_req),
  .host_rd        (host_rd),
  .host_rvalid    (host_rvalid),
  .dma_single_req (dma_single_req),
  .dma_burst_req  (dma_burst_req),
  .dma_ack        (dma_ack)
);

// File: tb/tb_irb_engine.sv
`timescale 1ns/1ps
module tb_irb_engine;
  localparam logic [31:0] KEY  = 32'h5A5A_0000;
  localparam logic [11:0] TRIG = 12'h200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        fl_req, fl_valid, fl_en = 1'b0;
  logic [31:0] fl_addr, fl_data;
  logic        dma_single_req, dma_burst_req, dma_ack = 1'b0;
  logic        irq_wm, irq_done;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  assign fl_valid = fl_req && fl_en;
  assign fl_data  = fl_addr ^ KEY;

  irb_engine dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_data(fl_data), .dma_single_req(dma_single_req),
    .dma_burst_req(dma_burst_req), .dma_ack(dma_ack), .irq_wm(irq_wm),
    .irq_done(irq_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected result into the scoreboard
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares as read data appears
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rvalid", host_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(!fl_req && !irq_wm && !irq_done && !dma_single_req && !dma_burst_req,
        "R1 outputs at reset", {27'b0, fl_req, irq_wm, irq_done, dma_single_req, dma_burst_req}, 32'h0);
    rd(12'd0, 32'h0, "R1 control after reset");
    rd(12'd6, 32'h0, "R1 fill after reset");

    // Scenario A: host-paced, 24 words, watermark 32 bytes
    wr(12'd1, 32'h0000_1000);
    wr(12'd2, 32'd96);
    wr(12'd3, {20'b0, TRIG});
    wr(12'd4, 32'd32);
    idle(5);
    chk(!fl_req, "R2 no fetch before start", {31'b0, fl_req}, 32'h0);
    wr(12'd0, 32'h1);
    idle(1);
    chk(fl_req && fl_addr == 32'h1000, "R2 first fetch address", fl_addr, 32'h1000);
    rd(12'd0, 32'h1, "R10 busy after start");
    fl_en = 1'b1;
    idle(5);
    fl_en = 1'b0;
    idle(2);
    chk(fl_addr == 32'h1014, "R2 address after five words", fl_addr, 32'h1014);
    rd(12'd6, 32'd20, "R4 fill five words");
    idle(2);
    chk(!irq_wm, "R5 below watermark", {31'b0, irq_wm}, 32'h0);
    fl_en = 1'b1;
    idle(30);
    chk(!fl_req, "R6 stall when full", {31'b0, fl_req}, 32'h0);
    chk(fl_addr == 32'h1040, "R6 sixteen words fetched", fl_addr, 32'h1040);
    rd(12'd6, 32'd64, "R4 fill when full");
    chk(irq_wm, "R5 at or above watermark", {31'b0, irq_wm}, 32'h1);
    // R10 restart attempt while busy
    wr(12'd1, 32'h0000_9000);
    wr(12'd0, 32'h1);
    rd(12'd0, 32'h1, "R10 restart ignored");
    for (int k = 0; k < 24; k++)
      rd(TRIG, (32'h1000 + 32'(4 * k)) ^ KEY, "R3 R10 trigger data order");
    idle(3);
    chk(irq_done, "R9 completion interrupt", {31'b0, irq_done}, 32'h1);
    chk(!fl_req, "R9 no fetch after done", {31'b0, fl_req}, 32'h0);
    rd(12'd0, 32'h2, "R9 done bit set");
    rd(TRIG, 32'h0, "R11 empty trigger read is zero");
    rd(12'd0, 32'h6, "R11 underflow flag");
    wr(12'd0, 32'h6);
    rd(12'd0, 32'h0, "R9 R11 write-one-to-clear");
    chk(!irq_done, "R9 interrupt cleared", {31'b0, irq_done}, 32'h0);

    // Scenario B: DMA, 6 words, burst 16 bytes, single 4 bytes, watermark 16
    fl_en = 1'b0;
    wr(12'd1, 32'h0000_2000);
    wr(12'd2, 32'd24);
    wr(12'd4, 32'd16);
    wr(12'd5, {16'd16, 16'd4});
    wr(12'd0, 32'h9);
    fl_en = 1'b1;
    idle(20);
    chk(dma_burst_req && !dma_single_req, "R7 burst request",
        {30'b0, dma_burst_req, dma_single_req}, 32'h2);
    chk(irq_wm, "R5 watermark in DMA mode", {31'b0, irq_wm}, 32'h1);
    rd(12'd6, 32'd24, "R4 fill six words");
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    idle(1);
    chk(!dma_burst_req && !dma_single_req, "R7 request drops after ack",
        {30'b0, dma_burst_req, dma_single_req}, 32'h0);
    for (int k = 0; k < 4; k++)
      rd(TRIG, (32'h2000 + 32'(4 * k)) ^ KEY, "R7 burst data");
    idle(3);
    chk(dma_single_req && !dma_burst_req, "R8 tail single request",
        {30'b0, dma_burst_req, dma_single_req}, 32'h1);
    for (int k = 4; k < 6; k++) begin
      @(negedge clk); dma_ack = 1'b1;
      @(negedge clk); dma_ack = 1'b0;
      rd(TRIG, (32'h2000 + 32'(4 * k)) ^ KEY, "R8 single data");
      idle(3);
    end
    chk(irq_done && !dma_single_req && !dma_burst_req, "R9 DMA transfer done",
        {29'b0, irq_done, dma_burst_req, dma_single_req}, 32'h4);
    rd(12'd0, 32'hA, "R9 done with DMA enable");
    idle(4);
    chk(exp_q.size() == 0, "R3 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule